// File: doc/BRIEF.md
# Burst Write Strobe Generator

This block takes one write burst request (a start byte address, a transfer size code and a beat-count field) and emits one byte-lane enable word per beat, in order, over a valid/ready beat interface. Each enable word marks the bytes that beat writes. The marked bytes start at the beat's own byte offset within the data bus and run for the beat's byte count. Any bytes that would lie past the top lane of the bus are dropped. Each beat address is the raw start address plus the beat index scaled by the beat size. The address is not aligned first, so an unaligned start keeps the same offset on every beat that does not cross a bus word.

A sequencer with two named states drives the block. ST_IDLE accepts a request when `aw_valid` meets `aw_ready`; this is the transition *accept*, which goes to ST_BEAT. ST_BEAT presents the current beat. On a completed beat handshake it takes one of two transitions: *advance* stays in ST_BEAT with the next beat index, and *finish* returns to ST_IDLE after the beat flagged last. A synchronous active-low reset forces ST_IDLE. The default build targets a 64-bit bus. `DATA_W` must be at least 16.

Top module: `burst_strobe_gen`

## Requirements
- R1: `st_strb` has `DATA_W/8` bits, with bit i standing for byte lane i. With offset = beat address modulo `DATA_W/8` and n = bytes per beat, bit i is 1 exactly when offset <= i <= offset+n-1 and i < `DATA_W/8`.
- R2: The bytes per beat are 2 to the power `aw_size`. A size code whose byte count exceeds `DATA_W/8` is treated as the code for exactly `DATA_W/8` bytes. This applies both to the lane mask and to the address step.
- R3: A burst carries `aw_len`+1 beats. The `st_addr` of beat k equals `aw_addr` + (k shifted left by the effective size code), modulo 2^`ADDR_W`.
- R4: `aw_ready` is 1 only in ST_IDLE. A request is taken on a cycle where `aw_valid` and `aw_ready` are both 1, and the first beat shows `st_valid`=1 in the next cycle.
- R5: While `st_valid`=1 and `st_ready`=0, the next cycle keeps `st_valid`=1 with `st_strb`, `st_addr` and `st_last` unchanged. The beat index advances only on a handshake.
- R6: `st_last` is 1 only on beat `aw_len`. After that beat's handshake, the next cycle has `st_valid`=0 and `aw_ready`=1.
- R7: When `rst_n` is sampled low at a clock edge, the next cycle shows `st_valid`=0 and `aw_ready`=1, even in the middle of a burst.
- R8: `aw_valid` asserted during a burst is ignored. `aw_ready` stays 0, and the remaining beats follow the original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Request offered |
| aw_ready | output | 1 | Block idle, request can be taken |
| aw_addr | input | ADDR_W | Start byte address |
| aw_size | input | 3 | Size code, bytes per beat = 2^code |
| aw_len | input | LEN_W | Beats minus one |
| st_valid | output | 1 | Beat strobe valid |
| st_ready | input | 1 | Downstream takes the beat |
| st_strb | output | DATA_W/8 | Byte-lane enables of the beat |
| st_addr | output | ADDR_W | Byte address of the beat |
| st_last | output | 1 | Final beat of the burst |

## Verification
The lane mask is tried with several kinds of request. An aligned full-width burst shows the mask covers the whole bus. Unaligned narrow bursts show the mask starts at the offset and not at lane 0. Requests whose beats run past the top lane show the mask is clipped rather than wrapped into low lanes. An oversize size code shows the clip to bus width. A start address near the top of the address space shows the beat address wraps and is taken from the raw start. Downstream stalls check that a beat is held, requests offered mid-burst check they are ignored, and a reset during a burst checks the return to idle.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } bsg_state_e;

    localparam int SZ_W = 3;
endpackage

// File: rtl/bsg_beat_addr.sv
module bsg_beat_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SZ_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  idx,
    input  logic [SZ_W-1:0]   sz_eff,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step = ADDR_W'(idx) << sz_eff;
        addr = base + step;
    end
endmodule

// File: rtl/bsg_lane_mask.sv
module bsg_lane_mask #(
    parameter int LANES = 8,
    parameter int OFF_W = 3,
    parameter int SZ_W  = 3
) (
    input  logic [OFF_W-1:0] off,
    input  logic [SZ_W-1:0]  sz_eff,
    output logic [LANES-1:0] mask
);
    localparam int CW = OFF_W + 2;

    logic [CW-1:0] n_bytes;
    logic [CW-1:0] lo;
    logic [CW-1:0] hi_excl;

    always_comb begin
        n_bytes = CW'(1) << sz_eff;
        lo      = CW'(off);
        hi_excl = lo + n_bytes;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (CW'(i) >= lo) && (CW'(i) < hi_excl);
    end
endmodule

// File: rtl/burst_strobe_gen.sv
module burst_strobe_gen
    import bsg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     aw_valid,
    output logic                     aw_ready,
    input  logic [ADDR_W-1:0]        aw_addr,
    input  logic [2:0]               aw_size,
    input  logic [LEN_W-1:0]         aw_len,
    output logic                     st_valid,
    input  logic                     st_ready,
    output logic [DATA_W/8-1:0]      st_strb,
    output logic [ADDR_W-1:0]        st_addr,
    output logic                     st_last
);
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int MAX_SZ = OFF_W;

    bsg_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [SZ_W-1:0]   szeff_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [SZ_W-1:0]   sz_clip;
    logic [ADDR_W-1:0] beat_addr;
    logic [LANES-1:0]  beat_mask;
    logic              take_req;
    logic              take_beat;
    logic              at_last;

    always_comb begin
        sz_clip   = (aw_size > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : aw_size;
        at_last   = (idx_q == len_q);
        take_req  = (state_q == ST_IDLE) && aw_valid;
        take_beat = (state_q == ST_BEAT) && st_ready;
    end

    bsg_beat_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SZ_W(SZ_W)) addr_i (
        .base   (base_q),
        .idx    (idx_q),
        .sz_eff (szeff_q),
        .addr   (beat_addr)
    );

    bsg_lane_mask #(.LANES(LANES), .OFF_W(OFF_W), .SZ_W(SZ_W)) mask_i (
        .off    (beat_addr[OFF_W-1:0]),
        .sz_eff (szeff_q),
        .mask   (beat_mask)
    );

    // state register and burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            szeff_q <= '0;
            len_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_req) begin
                        state_q <= ST_BEAT;
                        base_q  <= aw_addr;
                        szeff_q <= sz_clip;
                        len_q   <= aw_len;
                        idx_q   <= '0;
                    end
                end
                ST_BEAT: begin
                    if (take_beat) begin
                        if (at_last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        aw_ready = 1'b0;
        st_valid = 1'b0;
        st_last  = 1'b0;
        st_strb  = '0;
        st_addr  = '0;
        unique case (state_q)
            ST_IDLE: aw_ready = 1'b1;
            ST_BEAT: begin
                st_valid = 1'b1;
                st_last  = at_last;
                st_strb  = beat_mask;
                st_addr  = beat_addr;
            end
            default: aw_ready = 1'b0;
        endcase
    end

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid && aw_ready |=> st_valid && !aw_ready);

    assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_strb) && $stable(st_addr) && $stable(st_last));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && st_last |=> aw_ready && !st_valid);

    assert_offset_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> st_strb[st_addr[OFF_W-1:0]]);

    assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ($countones(st_strb) <= (32'd1 << szeff_q)));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !aw_ready);
endmodule

// File: tb/burst_strobe_gen_tb_top.sv
module burst_strobe_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        aw_valid;
    logic        aw_ready;
    logic [31:0] aw_addr;
    logic [2:0]  aw_size;
    logic [7:0]  aw_len;
    logic        st_valid;
    logic        st_ready;
    logic [7:0]  st_strb;
    logic [31:0] st_addr;
    logic        st_last;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int stall_t = 0;

    always #4 clk = ~clk;

    burst_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .aw_size(aw_size), .aw_len(aw_len),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_strb(st_strb), .st_addr(st_addr), .st_last(st_last)
    );

    // {start address, size code, length field, expected strobe of beat 0}
    localparam logic [51:0] VEC [8] = '{
        {32'h0000_0003, 4'd2, 8'd2,  8'h78},
        {32'h0000_0000, 4'd3, 8'd1,  8'hFF},
        {32'h0000_0005, 4'd0, 8'd4,  8'h20},
        {32'h0000_0006, 4'd1, 8'd3,  8'hC0},
        {32'h0000_0001, 4'd5, 8'd1,  8'hFE},
        {32'h0000_0007, 4'd2, 8'd0,  8'h80},
        {32'hFFFF_FFFE, 4'd1, 8'd2,  8'hC0},
        {32'h0000_0102, 4'd1, 8'd15, 8'h0C}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_eff(input int sz);
        return (sz > 3) ? 3 : sz;
    endfunction

    function automatic logic [7:0] m_strb(input logic [31:0] a, input int eff);
        logic [7:0] r;
        int off;
        int n;
        off = int'(a[2:0]);
        n = 1 << eff;
        for (int i = 0; i < 8; i++) r[i] = (i >= off) && (i < off + n);
        return r;
    endfunction

    task automatic run_burst(input logic [31:0] a, input int sz, input int len,
                             input logic [7:0] first_exp, input bit intrude);
        int eff;
        int b;
        logic [31:0] ea;
        bit rdy;
        eff = m_eff(sz);
        @(negedge clk);
        aw_valid = 1'b1; aw_addr = a; aw_size = 3'(sz); aw_len = 8'(len);
        chk("R4 aw_ready while idle", 64'(aw_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        chk("R4 first beat valid", 64'(st_valid), 64'd1);
        chk("R1 first beat strobe", 64'(st_strb), 64'(first_exp));
        b = 0;
        while (b <= len) begin
            if (intrude) begin
                aw_valid = 1'b1; aw_addr = 32'h40; aw_size = 3'd0; aw_len = 8'd0;
                chk("R8 aw_ready low while busy", 64'(aw_ready), 64'd0);
            end
            ea = a + (32'(b) << eff);
            chk("R5 valid held", 64'(st_valid), 64'd1);
            chk("R3 beat address", 64'(st_addr), 64'(ea));
            chk("R1 R2 beat strobe", 64'(st_strb), 64'(m_strb(ea, eff)));
            chk("R6 last flag", 64'(st_last), 64'(b == len));
            rdy = (stall_t % 3) != 2;
            stall_t++;
            st_ready = rdy;
            @(posedge clk);
            @(negedge clk);
            st_ready = 1'b0;
            aw_valid = 1'b0;
            if (rdy) b++;
        end
        chk("R6 idle after last", 64'(aw_ready), 64'd1);
        chk("R6 no valid after last", 64'(st_valid), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; aw_valid = 1'b0; aw_addr = '0; aw_size = '0; aw_len = '0; st_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset valid", 64'(st_valid), 64'd0);
        chk("R7 reset ready", 64'(aw_ready), 64'd1);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            run_burst(VEC[v][51:20], int'(VEC[v][19:16]), int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);
        end

        // requests offered mid-burst are ignored (R8)
        run_burst(32'h0000_0003, 2, 2, 8'h78, 1'b1);

        // reset during a burst (R7)
        @(negedge clk);
        aw_valid = 1'b1; aw_addr = 32'h11; aw_size = 3'd0; aw_len = 8'd5;
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        st_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        st_ready = 1'b0;
        chk("R3 second beat address before reset", 64'(st_addr), 64'h12);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid-burst reset valid", 64'(st_valid), 64'd0);
        chk("R7 mid-burst reset ready", 64'(aw_ready), 64'd1);
        rst_n = 1'b1;

        // fresh burst after reset starts from beat 0
        run_burst(32'h0000_0004, 2, 1, 8'hF0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule